// File: doc/BRIEF.md
# Cycle-Timed Rotate-Left Unit

This block carries out the register form of a rotate-left instruction for a processor that has 16-bit opcodes and 32-bit data registers. It takes the opcode, the value of the destination register, the value of a possible count register and the current condition codes. From these it produces the rotated register value and the updated condition codes.

The rotate count is either a 3-bit immediate in the opcode, where zero stands for eight, or the low six bits of a register value. The operand size is byte, word or long. Only the low part of the register that the size selects is rotated. The bits above it are passed through unchanged.

The result and flags are registered when a start is accepted. A one-cycle done pulse is then held back, so that each operation occupies an exact number of clock cycles. That number grows by two for every bit of count.

Top module: `rol_timed_unit`

## Requirements
- R1: With opcode bit 5 clear, the count is opcode bits 11:9, and a field value of 0 means a count of 8.
- R2: With opcode bit 5 set, the count is `cnt_reg_in` modulo 64, i.e. its bits 5:0.
- R3: Opcode bits 7:6 select the size: 00 byte (bits 7:0), 01 word (bits 15:0), 10 or 11 long (bits 31:0). Only the selected low part is rotated left, by count modulo its width. All bits above it equal `dreg_in`.
- R4: With a nonzero count, carry (flag bit 0) equals the least significant bit of the sized result.
- R5: The extend flag (flag bit 4) keeps the value of `flags_in[4]` in every case.
- R6: Overflow (flag bit 1) is always 0. N (flag bit 3) is the most significant bit of the sized result. Z (flag bit 2) is 1 exactly when the sized result is zero.
- R7: A byte or word operation lasts 6 + 2×count cycles. The cycle in which start is accepted counts as the first, so done rises on the (5 + 2×count)-th rising edge, counting the accepting edge as edge 1.
- R8: A long operation lasts 8 + 2×count cycles, measured in the same way.
- R9: A register count of 0 leaves the data unchanged, clears carry, keeps extend and lasts the base number of cycles (6, or 8 for long).
- R10: Done is high for exactly one cycle. A start raised while the unit is busy is ignored, and the result and flags do not change while busy.
- R11: A start is accepted only when opcode bit 8 is 1 (left rotate). Otherwise nothing happens: no done, and the outputs do not change.
- R12: After reset, done and busy are 0 and the result and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an operation |
| opcode | input | 16 | Instruction word |
| dreg_in | input | 32 | Destination register value |
| cnt_reg_in | input | 32 | Count register value |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| result | output | 32 | Rotated register value |
| flags_out | output | 5 | New flags {X,N,Z,V,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, a 6-bit register count, a base of 6 cycles (8 for long) and 2 cycles per bit. With these values the four byte counts 1, 2, 7 and 8 give the known latencies of 8, 10, 20 and 22 cycles. The 6-bit count field makes the longest case reachable: a long rotate by 63, which lasts 134 cycles. A register count of 64 then wraps to zero.

// File: rtl/rol_pkg.sv
package rol_pkg;
   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_LALT = 2'b11
   } size_t;
endpackage

// File: rtl/rol_count_decode.sv
module rol_count_decode #(
   parameter int OP_W      = 16,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 6,
   parameter int CYC_W     = 8,
   parameter int BASE_CYC  = 6,
   parameter int LONG_CYC  = 8,
   parameter int CYC_PER   = 2
) (
   input  logic [OP_W-1:0]   opcode,
   input  logic [DATA_W-1:0] cnt_reg_in,
   output logic [CNT_W-1:0]  count,
   output logic [CYC_W-1:0]  timer_load
);
   import rol_pkg::*;
   localparam int IMM_W = 3;

   logic [IMM_W-1:0] imm;
   logic [CYC_W-1:0] base;
   size_t            sz;

   always_comb begin
      imm = opcode[11:9];
      sz  = size_t'(opcode[7:6]);
      if (opcode[5])
         count = cnt_reg_in[CNT_W-1:0];
      else if (imm == '0)
         count = CNT_W'(8);
      else
         count = CNT_W'(imm);
      base = (sz == SZ_BYTE || sz == SZ_WORD) ? CYC_W'(BASE_CYC) : CYC_W'(LONG_CYC);
      // the done edge comes total-1 edges after acceptance; the timer needs total-3
      timer_load = base + CYC_W'(CYC_PER) * CYC_W'(count) - CYC_W'(3);
   end
endmodule

// File: rtl/rol_datapath.sv
module rol_datapath #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic [1:0]        size,
   input  logic [CNT_W-1:0]  count,
   input  logic [DATA_W-1:0] value,
   input  logic              x_in,
   output logic [DATA_W-1:0] res,
   output rol_pkg::ccr_t     ccr
);
   import rol_pkg::*;
   localparam int NLANE = 3;

   logic [DATA_W-1:0] lane_res [NLANE];
   logic              lane_msb [NLANE];
   logic              lane_zero[NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int W  = DATA_W >> (2 - g);
      localparam int SW = $clog2(W);
      logic [2*W-1:0] dbl;
      logic [W-1:0]   rot;
      always_comb begin
         dbl = {value[W-1:0], value[W-1:0]} << count[SW-1:0];
         rot = dbl[2*W-1:W];
         lane_msb[g]  = rot[W-1];
         lane_zero[g] = (rot == '0);
         if (W == DATA_W)
            lane_res[g] = DATA_W'(rot);
         else
            lane_res[g] = {value[DATA_W-1:W], rot} & {DATA_W{1'b1}};
      end
   end

   logic [1:0] idx;
   always_comb begin
      case (size_t'(size))
         SZ_BYTE: idx = 2'd0;
         SZ_WORD: idx = 2'd1;
         default: idx = 2'd2;
      endcase
      res    = lane_res[idx];
      ccr.x  = x_in;
      ccr.n  = lane_msb[idx];
      ccr.z  = lane_zero[idx];
      ccr.v  = 1'b0;
      ccr.c  = (count != '0) ? res[0] : 1'b0;
   end
endmodule

// File: rtl/rol_timer.sv
module rol_timer #(
   parameter int CYC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CYC_W-1:0] load_val,
   output logic             busy,
   output logic             done
);
   logic [CYC_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load && !busy) begin
            remain <= load_val;
            busy   <= 1'b1;
         end else if (busy) begin
            if (remain == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rol_timed_unit.sv
module rol_timed_unit #(
   parameter int OP_W     = 16,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 6,
   parameter int CYC_W    = 8,
   parameter int BASE_CYC = 6,
   parameter int LONG_CYC = 8,
   parameter int CYC_PER  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   opcode,
   input  logic [DATA_W-1:0] dreg_in,
   input  logic [DATA_W-1:0] cnt_reg_in,
   input  logic [4:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [4:0]        flags_out,
   output logic              busy,
   output logic              done
);
   import rol_pkg::*;
   localparam int MAX_CYC = LONG_CYC + CYC_PER * ((1 << CNT_W) - 1);

   initial begin
      assert (OP_W >= 12) else $error("opcode too narrow");
      assert (DATA_W >= 32 && (DATA_W & (DATA_W - 1)) == 0) else $error("DATA_W must be a power of two >= 32");
      assert (BASE_CYC >= 3 && LONG_CYC >= 3) else $error("base latency too small");
      assert (MAX_CYC < (1 << CYC_W)) else $error("CYC_W too narrow");
      assert (CNT_W >= 4 && CNT_W <= DATA_W) else $error("CNT_W out of range");
   end

   logic [CNT_W-1:0]  count;
   logic [CYC_W-1:0]  tload;
   logic [DATA_W-1:0] dp_res;
   ccr_t              dp_ccr;
   logic              accept;

   assign accept = start && !busy && opcode[8];

   rol_count_decode #(.OP_W(OP_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CYC_W(CYC_W),
      .BASE_CYC(BASE_CYC), .LONG_CYC(LONG_CYC), .CYC_PER(CYC_PER)) u_dec (
      .opcode(opcode), .cnt_reg_in(cnt_reg_in), .count(count), .timer_load(tload));

   rol_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
      .size(opcode[7:6]), .count(count), .value(dreg_in), .x_in(flags_in[4]),
      .res(dp_res), .ccr(dp_ccr));

   rol_timer #(.CYC_W(CYC_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(tload),
      .busy(busy), .done(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         flags_out <= '0;
      end else if (accept) begin
         result    <= dp_res;
         flags_out <= dp_ccr;
      end
   end
endmodule

module rol_timed_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [15:0]       opcode,
   input logic [DATA_W-1:0] dreg_in,
   input logic [4:0]        flags_in,
   input logic [DATA_W-1:0] result,
   input logic [4:0]        flags_out,
   input logic              busy,
   input logic              done
);
   logic       x_seen;
   logic [1:0] sz_seen;
   logic [DATA_W-1:0] d_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_seen  <= 1'b0;
         sz_seen <= 2'b00;
         d_seen  <= '0;
      end else if (start && !busy && opcode[8]) begin
         x_seen  <= flags_in[4];
         sz_seen <= opcode[7:6];
         d_seen  <= dreg_in;
      end
   end

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(result) && $stable(flags_out)));
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !flags_out[1]);
   p_keep_x_r5: assert property (@(posedge clk) disable iff (!rst_n) done |-> flags_out[4] == x_seen);
   p_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((sz_seen == 2'b00) ? result[DATA_W-1:8] == d_seen[DATA_W-1:8] :
                (sz_seen == 2'b01) ? result[DATA_W-1:16] == d_seen[DATA_W-1:16] : 1'b1));
   p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(start && opcode[8])) |=> !busy);
endmodule

bind rol_timed_unit rol_timed_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .dreg_in(dreg_in),
   .flags_in(flags_in), .result(result), .flags_out(flags_out), .busy(busy), .done(done));

// File: tb/rol_timed_unit_bench.sv
module rol_timed_unit_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        start = 0;
   logic [15:0] opcode = '0;
   logic [31:0] dreg_in = '0;
   logic [31:0] cnt_reg_in = '0;
   logic [4:0]  flags_in = '0;
   logic [31:0] result;
   logic [4:0]  flags_out;
   logic        busy, done;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   rol_timed_unit u_rol_timed_unit (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // run one operation; exp_edges = total cycles - 1
   task automatic run_op(input string tag, input logic [15:0] op, input logic [31:0] d,
                         input logic [31:0] c, input logic [4:0] f, input logic [31:0] exp_r,
                         input logic [4:0] exp_f, input int exp_edges);
      int edges = 0;
      @(negedge clk);
      opcode = op; dreg_in = d; cnt_reg_in = c; flags_in = f; start = 1;
      for (int i = 1; i <= 300; i++) begin
         @(posedge clk); #1;
         start = 0;
         if (done) begin edges = i; break; end
      end
      chk({tag, " result"}, result, exp_r);
      chk({tag, " flags"}, {27'd0, flags_out}, {27'd0, exp_f});
      chk({tag, " edges"}, edges, exp_edges);
      @(posedge clk); #1;
      chk({tag, " done one cycle R10"}, {31'd0, done}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R12 done", {31'd0, done}, 0);
      chk("R12 busy", {31'd0, busy}, 0);
      chk("R12 result", result, 0);
      chk("R12 flags", {27'd0, flags_out}, 0);
   endtask

   // flags {X,N,Z,V,C}: X=10 N=08 Z=04 V=02 C=01
   task automatic t_byte_imm;
      run_op("R1 R4 R7 byte cnt8", 16'hE118, 32'hCE3DD567, 0, 5'h00, 32'hCE3DD567, 5'h01, 21);
      run_op("R6 R7 byte cnt1",    16'hE318, 32'hCE3DD567, 0, 5'h00, 32'hCE3DD5CE, 5'h08, 7);
      run_op("R5 R4 byte cnt2",    16'hE518, 32'hCE3DD567, 0, 5'h1F, 32'hCE3DD59D, 5'h19, 9);
      run_op("R3 R7 byte cnt7",    16'hEF18, 32'hCE3DD567, 0, 5'h1F, 32'hCE3DD5B3, 5'h19, 19);
      run_op("R6 byte zero",       16'hE718, 32'h12345600, 0, 5'h00, 32'h12345600, 5'h04, 11);
   endtask

   task automatic t_word;
      run_op("R3 R5 word cnt8", 16'hE158, 32'hCE3DD567, 0, 5'h1F, 32'hCE3D67D5, 5'h11, 21);
   endtask

   task automatic t_long;
      run_op("R8 long cnt3",       16'hE798, 32'hA0000000, 0, 5'h00, 32'h00000005, 5'h01, 13);
      run_op("R2 R8 long reg63",   16'hE1B8, 32'h00000001, 32'd63, 5'h00, 32'h80000000, 5'h08, 133);
   endtask

   task automatic t_reg_count;
      run_op("R2 byte reg65",      16'hE138, 32'hCE3DD567, 32'd65, 5'h00, 32'hCE3DD5CE, 5'h08, 7);
      run_op("R9 byte reg64",      16'hE138, 32'hCE3DD567, 32'd64, 5'h11, 32'hCE3DD567, 5'h10, 5);
   endtask

   task automatic t_busy_ignore;
      int edges = 0;
      @(negedge clk);
      opcode = 16'hE318; dreg_in = 32'hCE3DD567; flags_in = 0; start = 1;
      @(posedge clk); #1;
      opcode = 16'hE518; dreg_in = 32'h0000FFFF; start = 1;
      for (int i = 2; i <= 100; i++) begin
         @(posedge clk); #1;
         if (done) begin edges = i; break; end
      end
      start = 0;
      chk("R10 busy start ignored result", result, 32'hCE3DD5CE);
      chk("R10 busy start ignored edges", edges, 7);
      for (int i = 0; i < 30; i++) begin
         @(posedge clk); #1;
         if (done) edges = -1;
      end
      chk("R10 no second done", edges, 7);
   endtask

   task automatic t_not_left;
      logic seen = 0;
      @(negedge clk);
      opcode = 16'hE018; dreg_in = 32'h11111111; flags_in = 5'h1F; start = 1;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #1;
         if (done || busy) seen = 1;
      end
      start = 0;
      chk("R11 no done", {31'd0, seen}, 0);
      chk("R11 result held", result, 32'hCE3DD5CE);
      chk("R11 flags held", {27'd0, flags_out}, 32'h08);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1;
      t_reset;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
      t_reset;
      t_byte_imm;
      t_word;
      t_long;
      t_reg_count;
      t_busy_ignore;
      t_not_left;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule